// File: doc/BRIEF.md
# Single-Cycle Integer Execute Unit

This block executes one 32-bit instruction word per clock for a small 64-bit integer subset. Each cycle the surrounding fetch logic presents the instruction and its program counter. The block decodes the word, reads up to two source registers from a 32-entry register file, forms a result, commits it to the register file on the next rising edge, and returns the address of the following instruction the same cycle.

The supported set covers register and immediate addition, upper-immediate load, logical left shift, signed set-less-than, a conditional move on zero, three PC-relative branches, region-preserving direct jumps with and without link, and register-indirect jumps with and without link. Any word outside this set raises an illegal flag, changes no register and steps the program counter by four. The write-back triple (enable, address, data) is a port so that the register file can be watched from outside.

Field layout: opcode in bits 31..26, rs in 25..21, rt in 20..16, rd in 15..11, shift amount in 10..6, function code in 5..0, 16-bit immediate in 15..0, 26-bit jump target in 25..0. Register 31 is the link register.

Top module: `rx_exec_unit`

## Requirements
- R1: Register 0 always reads as zero; an instruction naming it as destination leaves wrEn low.
- R2: Opcode 000000 with function 101100 writes rs + rt into rd (wrEn high, wrAddr = rd).
- R3: Opcode 011001 writes rs plus the sign-extended 16-bit immediate into rt.
- R4: Opcode 001111 writes, from most to least significant, 32 zero bits, the immediate, then 16 zero bits into rt.
- R5: Opcode 000000 with function 111000 writes rt shifted left by the 5-bit shift field into rd.
- R6: Opcode 000000 with function 101010 writes 1 into rd when rs is less than rt as signed numbers, else 0.
- R7: Opcode 000000 with function 001010 copies rs into rd only when rt equals zero; otherwise wrEn stays low and rd keeps its value.
- R8: Opcodes 000100 (rs equal rt), 000101 (rs not equal rt) and 000110 (rs equal zero) branch to pc + 4 + (sign-extended immediate shifted left by 2) when the condition holds, otherwise to pc + 4; none of them writes a register.
- R9: Opcode 000010 sets the next PC to pc bits 63..28 followed by the target field and two zero bits; opcode 000011 does the same and also writes pc + 4 into register 31.
- R10: Opcode 000000 with function 001000 jumps to the value of rs; function 001001 does the same and writes pc + 4 into register 31.
- R11: Any other opcode or function code drives illegal high, keeps wrEn low and sets the next PC to pc + 4.
- R12: Reset clears every register to zero; every non-control-flow instruction sets the next PC to pc + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes commit on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word for this cycle |
| pc | input | XLEN | Address of the instruction |
| nextPc | output | XLEN | Address of the following instruction |
| wrEn | output | 1 | Register write happens at the next edge |
| wrAddr | output | 5 | Destination register of that write |
| wrData | output | XLEN | Value being written |
| illegal | output | 1 | Instruction word not recognised |

## Verification
The bench builds the unit with the default XLEN of 64, so that the upper 32 bits produced by the upper-immediate load, shifts that move bits past position 31, and the 36 preserved region bits of a direct jump all become observable. Program counters with high bits set are fed to the jumps to prove those bits survive. Register contents that an instruction must leave alone are read back through a later add with register 0.

// File: rtl/rx_pkg.sv
package rx_pkg;

  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_ADDI  = 6'b011001;
  localparam logic [5:0] OP_LUI   = 6'b001111;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] OP_BZ    = 6'b000110;
  localparam logic [5:0] OP_JMP   = 6'b000010;
  localparam logic [5:0] OP_JLNK  = 6'b000011;

  localparam logic [5:0] FN_ADD   = 6'b101100;
  localparam logic [5:0] FN_SLL   = 6'b111000;
  localparam logic [5:0] FN_SLT   = 6'b101010;
  localparam logic [5:0] FN_CMOVZ = 6'b001010;
  localparam logic [5:0] FN_JREG  = 6'b001000;
  localparam logic [5:0] FN_JRLNK = 6'b001001;

  localparam logic [4:0] LINK_REG = 5'd31;

  typedef enum logic [2:0] {RES_ADD, RES_SLL, RES_SLT, RES_LUI, RES_MOVE, RES_LINK} resSel_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dstSel_e;
  typedef enum logic [1:0] {BR_NONE, BR_EQ, BR_NE, BR_ZERO} brKind_e;

  typedef struct packed {
    logic    regWrite;
    dstSel_e dstSel;
    resSel_e resSel;
    logic    useImm;
    logic    condZero;
    brKind_e brKind;
    logic    jumpDirect;
    logic    jumpReg;
    logic    illegal;
  } ctrl_t;

endpackage

// File: rtl/rx_control.sv
module rx_control
  import rx_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.dstSel = DST_RD;
    ctrl.resSel = RES_ADD;
    ctrl.brKind = BR_NONE;
    unique case (opcode)
      OP_REG: begin
        unique case (funct)
          FN_ADD:   ctrl.regWrite = 1'b1;
          FN_SLL:   begin ctrl.regWrite = 1'b1; ctrl.resSel = RES_SLL; end
          FN_SLT:   begin ctrl.regWrite = 1'b1; ctrl.resSel = RES_SLT; end
          FN_CMOVZ: begin
            ctrl.regWrite = 1'b1;
            ctrl.resSel   = RES_MOVE;
            ctrl.condZero = 1'b1;
          end
          FN_JREG:  ctrl.jumpReg = 1'b1;
          FN_JRLNK: begin
            ctrl.jumpReg  = 1'b1;
            ctrl.regWrite = 1'b1;
            ctrl.resSel   = RES_LINK;
            ctrl.dstSel   = DST_LINK;
          end
          default:  ctrl.illegal = 1'b1;
        endcase
      end
      OP_ADDI: begin
        ctrl.regWrite = 1'b1;
        ctrl.useImm   = 1'b1;
        ctrl.dstSel   = DST_RT;
      end
      OP_LUI: begin
        ctrl.regWrite = 1'b1;
        ctrl.resSel   = RES_LUI;
        ctrl.dstSel   = DST_RT;
      end
      OP_BEQ:  ctrl.brKind = BR_EQ;
      OP_BNE:  ctrl.brKind = BR_NE;
      OP_BZ:   ctrl.brKind = BR_ZERO;
      OP_JMP:  ctrl.jumpDirect = 1'b1;
      OP_JLNK: begin
        ctrl.jumpDirect = 1'b1;
        ctrl.regWrite   = 1'b1;
        ctrl.resSel     = RES_LINK;
        ctrl.dstSel     = DST_LINK;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  input  ctrl_t           ctrl,
  output logic            wrEn,
  output logic [4:0]      wrAddr,
  output logic [XLEN-1:0] wrData,
  output logic [XLEN-1:0] nextPc
);

  localparam int REG_COUNT = 32;
  localparam int HI_PAD    = XLEN - 32;
  localparam int IMM_PAD   = XLEN - 16;
  localparam int OFS_PAD   = XLEN - 18;

  logic [XLEN-1:0] regs [REG_COUNT];

  logic [4:0]  rsIdx, rtIdx, rdIdx, shAmt;
  logic [15:0] imm16;
  logic [25:0] target;
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign shAmt  = instr[10:6];
  assign imm16  = instr[15:0];
  assign target = instr[25:0];

  logic [XLEN-1:0] rsVal, rtVal, immExt, opB, pcPlus4, brTarget, jmpTarget, result;
  logic            sltBit, brTaken, condOk;
  logic [4:0]      dstAddr;

  assign rsVal     = (rsIdx == 5'd0) ? '0 : regs[rsIdx];
  assign rtVal     = (rtIdx == 5'd0) ? '0 : regs[rtIdx];
  assign immExt    = {{IMM_PAD{imm16[15]}}, imm16};
  assign opB       = ctrl.useImm ? immExt : rtVal;
  assign pcPlus4   = pc + XLEN'(4);
  assign brTarget  = pcPlus4 + {{OFS_PAD{imm16[15]}}, imm16, 2'b00};
  assign jmpTarget = {pc[XLEN-1:28], target, 2'b00};
  assign sltBit    = $signed(rsVal) < $signed(rtVal);

  always_comb begin
    unique case (ctrl.resSel)
      RES_SLL:  result = rtVal << shAmt;
      RES_SLT:  result = {{(XLEN-1){1'b0}}, sltBit};
      RES_LUI:  result = {{HI_PAD{1'b0}}, imm16, 16'h0000};
      RES_MOVE: result = rsVal;
      RES_LINK: result = pcPlus4;
      default:  result = rsVal + opB;
    endcase
  end

  always_comb begin
    unique case (ctrl.dstSel)
      DST_RT:   dstAddr = rtIdx;
      DST_LINK: dstAddr = LINK_REG;
      default:  dstAddr = rdIdx;
    endcase
  end

  assign condOk = !ctrl.condZero || (rtVal == '0);
  assign wrEn   = ctrl.regWrite && !ctrl.illegal && condOk && (dstAddr != 5'd0);
  assign wrAddr = dstAddr;
  assign wrData = result;

  always_comb begin
    unique case (ctrl.brKind)
      BR_EQ:   brTaken = (rsVal == rtVal);
      BR_NE:   brTaken = (rsVal != rtVal);
      BR_ZERO: brTaken = (rsVal == '0);
      default: brTaken = 1'b0;
    endcase
  end

  always_comb begin
    if (ctrl.jumpReg)         nextPc = rsVal;
    else if (ctrl.jumpDirect) nextPc = jmpTarget;
    else if (brTaken)         nextPc = brTarget;
    else                      nextPc = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (wrEn) begin
      regs[wrAddr] <= wrData;
    end
  end

  // R1: storage behind register 0 never changes from zero
  a_r1_zero_reg_clear: assert property (@(posedge clk) disable iff (!rstN)
    regs[0] == '0);

  // R2: an announced write lands in the register file
  a_r2_write_commits: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> regs[$past(wrAddr)] == $past(wrData));

  // R7: a nonzero condition register blocks the conditional move
  a_r7_cmov_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.condZero && rtVal != '0) |-> !wrEn);

  // R9: link writes carry the return address into register 31
  a_r9_link_value: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ctrl.dstSel == DST_LINK) |-> (wrAddr == 5'd31 && wrData == pc + XLEN'(4)));

endmodule

// File: rtl/rx_exec_unit.sv
module rx_exec_unit
  import rx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] nextPc,
  output logic            wrEn,
  output logic [4:0]      wrAddr,
  output logic [XLEN-1:0] wrData,
  output logic            illegal
);

  ctrl_t ctrl;

  rx_control u_control (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  rx_datapath #(.XLEN(XLEN)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .instr  (instr),
    .pc     (pc),
    .ctrl   (ctrl),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .nextPc (nextPc)
  );

  assign illegal = ctrl.illegal;

  // R11: unrecognised words write nothing and step by four
  a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!wrEn && nextPc == pc + XLEN'(4)));

  // R8: branches never write the register file
  a_r8_branch_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.brKind != BR_NONE) |-> !wrEn);

endmodule

// File: tb/rx_exec_unit_bench.sv
module rx_exec_unit_bench;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [31:0]     instr = 32'h0;
  logic [XLEN-1:0] pc = '0;
  logic [XLEN-1:0] nextPc;
  logic            wrEn;
  logic [4:0]      wrAddr;
  logic [XLEN-1:0] wrData;
  logic            illegal;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  rx_exec_unit #(.XLEN(XLEN)) u_rx_exec_unit (
    .clk(clk), .rstN(rstN), .instr(instr), .pc(pc),
    .nextPc(nextPc), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .illegal(illegal)
  );

  function automatic logic [31:0] encR(input logic [5:0] fn, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [4:0] rd,
                                       input logic [4:0] sh);
    return {6'b000000, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] encI(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] encJ(input logic [5:0] op, input logic [25:0] tgt);
    return {op, tgt};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one instruction between edges, sample after settling
  task automatic step(input logic [31:0] i, input logic [63:0] p);
    @(negedge clk);
    instr = i;
    pc    = p;
    #1;
  endtask

  task automatic expectWrite(input string tag, input logic [4:0] addr, input logic [63:0] val,
                             input logic [63:0] p);
    chk({tag, " wrEn"}, 64'(wrEn), 64'd1);
    chk({tag, " wrAddr"}, 64'(wrAddr), 64'(addr));
    chk({tag, " wrData"}, wrData, val);
    chk({tag, " nextPc"}, nextPc, p + 64'd4);
  endtask

  task automatic readReg(input logic [4:0] r, output logic [63:0] v);
    step(encR(6'b101100, r, 5'd0, 5'd20, 5'd0), 64'h100);
    v = wrData;
  endtask

  task automatic testReset();
    logic [63:0] v;
    for (int r = 1; r < 32; r += 10) begin
      readReg(5'(r), v);
      chk("R12 reset clears register", v, 64'd0);
    end
  endtask

  task automatic testArith();
    step(encI(6'b001111, 5'd0, 5'd1, 16'h1234), 64'h200);
    expectWrite("R4 upper immediate", 5'd1, 64'h0000_0000_1234_0000, 64'h200);
    step(encI(6'b001111, 5'd0, 5'd11, 16'hF00D), 64'h204);
    expectWrite("R4 upper immediate high bit", 5'd11, 64'h0000_0000_F00D_0000, 64'h204);
    step(encI(6'b011001, 5'd0, 5'd2, 16'hFFFB), 64'h208);
    expectWrite("R3 add immediate negative", 5'd2, 64'hFFFF_FFFF_FFFF_FFFB, 64'h208);
    step(encI(6'b011001, 5'd0, 5'd3, 16'h0007), 64'h20C);
    expectWrite("R3 add immediate positive", 5'd3, 64'd7, 64'h20C);
    step(encR(6'b101100, 5'd2, 5'd3, 5'd4, 5'd0), 64'h210);
    expectWrite("R2 register add", 5'd4, 64'd2, 64'h210);
    step(encR(6'b101100, 5'd1, 5'd11, 5'd12, 5'd0), 64'h214);
    expectWrite("R2 register add wide", 5'd12, 64'h0000_0001_0241_0000, 64'h214);
  endtask

  task automatic testZeroReg();
    logic [63:0] v;
    step(encI(6'b011001, 5'd3, 5'd0, 16'h0055), 64'h300);
    chk("R1 write to r0 suppressed", 64'(wrEn), 64'd0);
    step(encR(6'b101100, 5'd0, 5'd0, 5'd5, 5'd0), 64'h304);
    expectWrite("R1 r0 reads zero", 5'd5, 64'd0, 64'h304);
    readReg(5'd0, v);
    chk("R1 r0 still zero", v, 64'd0);
  endtask

  task automatic testShiftCompare();
    step(encR(6'b111000, 5'd0, 5'd3, 5'd6, 5'd4), 64'h400);
    expectWrite("R5 shift by 4", 5'd6, 64'h70, 64'h400);
    step(encR(6'b111000, 5'd0, 5'd3, 5'd13, 5'd31), 64'h404);
    expectWrite("R5 shift by 31", 5'd13, 64'h3_8000_0000, 64'h404);
    step(encR(6'b101010, 5'd2, 5'd3, 5'd7, 5'd0), 64'h408);
    expectWrite("R6 signed less", 5'd7, 64'd1, 64'h408);
    step(encR(6'b101010, 5'd3, 5'd2, 5'd7, 5'd0), 64'h40C);
    expectWrite("R6 signed not less", 5'd7, 64'd0, 64'h40C);
    step(encR(6'b101010, 5'd3, 5'd3, 5'd7, 5'd0), 64'h410);
    expectWrite("R6 equal not less", 5'd7, 64'd0, 64'h410);
  endtask

  task automatic testCondMove();
    logic [63:0] v;
    step(encR(6'b001010, 5'd3, 5'd2, 5'd8, 5'd0), 64'h500);
    chk("R7 cmov blocked wrEn", 64'(wrEn), 64'd0);
    chk("R7 cmov blocked nextPc", nextPc, 64'h504);
    readReg(5'd8, v);
    chk("R7 cmov destination kept", v, 64'd0);
    step(encR(6'b001010, 5'd3, 5'd0, 5'd8, 5'd0), 64'h508);
    expectWrite("R7 cmov taken", 5'd8, 64'd7, 64'h508);
    readReg(5'd8, v);
    chk("R7 cmov committed", v, 64'd7);
  endtask

  task automatic testBranches();
    step(encI(6'b000100, 5'd3, 5'd3, 16'hFFFE), 64'h1000);
    chk("R8 beq taken backward", nextPc, 64'h0FFC);
    chk("R8 beq no write", 64'(wrEn), 64'd0);
    step(encI(6'b000100, 5'd3, 5'd2, 16'hFFFE), 64'h1000);
    chk("R8 beq not taken", nextPc, 64'h1004);
    step(encI(6'b000101, 5'd3, 5'd3, 16'h0003), 64'h1000);
    chk("R8 bne not taken", nextPc, 64'h1004);
    step(encI(6'b000101, 5'd2, 5'd3, 16'h0003), 64'h1000);
    chk("R8 bne taken", nextPc, 64'h1010);
    step(encI(6'b000110, 5'd0, 5'd0, 16'h0001), 64'h1000);
    chk("R8 bz taken", nextPc, 64'h1008);
    step(encI(6'b000110, 5'd3, 5'd0, 16'h0001), 64'h1000);
    chk("R8 bz not taken", nextPc, 64'h1004);
    chk("R8 bz no write", 64'(wrEn), 64'd0);
  endtask

  task automatic testJumps();
    logic [63:0] p;
    logic [25:0] tgt;
    p   = 64'hA000_0000_1234_5678;
    tgt = 26'h0ABCDEF;
    step(encJ(6'b000010, tgt), p);
    chk("R9 jump region kept", nextPc, {p[63:28], tgt, 2'b00});
    chk("R9 jump no write", 64'(wrEn), 64'd0);
    step(encJ(6'b000011, tgt), p);
    chk("R9 jal target", nextPc, {p[63:28], tgt, 2'b00});
    chk("R9 jal link enable", 64'(wrEn), 64'd1);
    chk("R9 jal link reg", 64'(wrAddr), 64'd31);
    chk("R9 jal link data", wrData, p + 64'd4);
    step(encR(6'b001000, 5'd3, 5'd0, 5'd0, 5'd0), 64'h2000);
    chk("R10 jr target", nextPc, 64'd7);
    chk("R10 jr no write", 64'(wrEn), 64'd0);
    step(encR(6'b001001, 5'd6, 5'd0, 5'd0, 5'd0), 64'h2000);
    chk("R10 jalr target", nextPc, 64'h70);
    chk("R10 jalr link reg", 64'(wrAddr), 64'd31);
    chk("R10 jalr link data", wrData, 64'h2004);
  endtask

  task automatic testIllegal();
    logic [63:0] v;
    step(32'hFC00_0000 | encI(6'b000000, 5'd1, 5'd3, 16'h0), 64'h3000);
    chk("R11 bad opcode flag", 64'(illegal), 64'd1);
    chk("R11 bad opcode no write", 64'(wrEn), 64'd0);
    chk("R11 bad opcode nextPc", nextPc, 64'h3004);
    step(encR(6'b111111, 5'd2, 5'd2, 5'd3, 5'd0), 64'h3004);
    chk("R11 bad function flag", 64'(illegal), 64'd1);
    chk("R11 bad function no write", 64'(wrEn), 64'd0);
    readReg(5'd3, v);
    chk("R11 destination kept", v, 64'd7);
    chk("R11 legal clears flag", 64'(illegal), 64'd0);
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    instr = encR(6'b101100, 5'd0, 5'd0, 5'd0, 5'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testArith();
    testZeroReg();
    testShiftCompare();
    testCondMove();
    testBranches();
    testJumps();
    testIllegal();
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule